// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This block watches 32 general-purpose input pins, split into a low half (pins 0 to 15) and a high half (pins 16 to 31). Each pin has its own detection setup: level or edge sensing, the active level for level sensing, sticky or follow-the-event status, and, in the edge-select build, an enable for each edge direction. Pin inputs pass through a synchronizer first, so they may come straight from pads.

A pending-status register and an enable mask are kept for each half, and software reaches them through a small 16-bit register port. A single interrupt line is asserted when any pin is both pending and enabled. A priority output gives the number of the lowest-numbered pending and enabled pin, and every pin in the low half wins over every pin in the high half. Software reads this number to find the pin to service.

Top module: `gpio_irq_unit`

## Requirements
- R1: Register map (byte address, bit 0 ignored; bit n of a low register is pin n, bit n of a high register is pin n+16): 0x00/0x02 status, 0x04/0x06 enable, 0x08/0x0A type (1 = edge, 0 = level), 0x0C/0x0E active level (1 = high), 0x10/0x12 sticky select (1 = sticky), 0x14/0x16 falling-edge enable, 0x18/0x1A rising-edge enable. Writing a 1 to a status bit clears a sticky pending bit. Writing a 0 leaves it unchanged. Reads return the current register value.
- R2: irq_out is a register. It is 1 in the cycle after any status bit and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R3: For a level-type pin the status bit is reloaded every cycle with (synchronized pin == active level). A status clear write has no lasting effect on it.
- R4: For an edge-type sticky pin a qualifying edge sets the status bit, and the bit stays at 1 until a clear write. If an edge and a clear arrive in the same cycle, the edge wins.
- R5: For an edge-type non-sticky pin the status bit is 1 for exactly the one cycle that follows each qualifying edge.
- R6: A rising edge qualifies only when the pin's rising-edge enable is 1, and a falling edge only when its falling-edge enable is 1. The active-level select has no effect on edge-type pins.
- R7: pend_idx gives the lowest-numbered pin in the low half that is pending and enabled. If the low half has none, it gives 16 plus the lowest such bit of the high half. pend_valid is 0 when neither half has such a pin. Both outputs are combinational from the status and enable registers.
- R8: A pin change is seen through a two-stage synchronizer. The status bit reflects a change that was driven before clock edge k at clock edge k+2.
- R9: After reset the registers read: status 0, enable 0, type 0, active level 0xFFFF, sticky 0, both edge enables 0xFFFF.
- R10: Addresses 0x1C and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| irq_out | output | 1 | Combined registered interrupt |
| pend_idx | output | 5 | Number of the highest-priority pending, enabled pin |
| pend_valid | output | 1 | pend_idx is meaningful |

## Verification
The hardest case to reach is a sticky edge pin that gets a new edge in the same cycle as its clear write, while pins in the other half are pending, so that priority and the set-over-clear rule both matter at once. A directed sequence times a pin toggle so that the edge reaches the detector in the exact cycle of the clear write. A long random phase then mixes sparse pin toggles with random writes to every register. At each cycle it compares the status, interrupt and priority outputs against a cycle model kept in the bench.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int REG_W   = 16;
   localparam int ADDR_W  = 6;
   localparam int N_KINDS = 7;

   typedef enum logic [3:0] {
      K_STAT = 4'd0,
      K_EN   = 4'd1,
      K_TYPE = 4'd2,
      K_POL  = 4'd3,
      K_HOLD = 4'd4,
      K_FALL = 4'd5,
      K_RISE = 4'd6
   } reg_kind_e;

   function automatic logic kind_is_ones(input int k);
      return (k == K_POL) || (k == K_FALL) || (k == K_RISE);
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= '0;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int HALF_W   = 16,
   parameter bit EDGE_SEL = 1'b1,
   localparam int N       = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [N-1:0]      status,
   output logic [REG_W-1:0]  rdata,
   output logic [N-1:0]      clr,
   output logic [N-1:0]      en,
   output logic [N-1:0]      typ,
   output logic [N-1:0]      pol,
   output logic [N-1:0]      hold,
   output logic [N-1:0]      fall_en,
   output logic [N-1:0]      rise_en
);
   localparam int IDX_W  = ADDR_W - 1;
   localparam int KIND_W = IDX_W - 1;

   logic [IDX_W-1:0]  idx;
   logic [KIND_W-1:0] kind;
   logic              half;
   logic              kind_ok;
   logic              is_stat;
   logic [HALF_W-1:0] cfg_q [N_KINDS][2];

   assign idx     = addr[ADDR_W-1:1];
   assign kind    = idx[IDX_W-1:1];
   assign half    = idx[0];
   assign is_stat = (kind == KIND_W'(K_STAT));
   assign kind_ok = (kind > KIND_W'(K_STAT)) &&
                    (kind < (EDGE_SEL ? KIND_W'(N_KINDS) : KIND_W'(K_FALL)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_KINDS; k++)
            for (int h = 0; h < 2; h++)
               cfg_q[k][h] <= kind_is_ones(k) ? '1 : '0;
      end else if (wr && kind_ok) begin
         cfg_q[kind][half] <= wdata[HALF_W-1:0];
      end
   end

   always_comb begin
      clr = '0;
      if (wr && is_stat) clr[half*HALF_W +: HALF_W] = wdata[HALF_W-1:0];
   end

   always_comb begin
      rdata = '0;
      if (is_stat)      rdata = REG_W'(status[half*HALF_W +: HALF_W]);
      else if (kind_ok) rdata = REG_W'(cfg_q[kind][half]);
   end

   assign en   = {cfg_q[K_EN][1],   cfg_q[K_EN][0]};
   assign typ  = {cfg_q[K_TYPE][1], cfg_q[K_TYPE][0]};
   assign pol  = {cfg_q[K_POL][1],  cfg_q[K_POL][0]};
   assign hold = {cfg_q[K_HOLD][1], cfg_q[K_HOLD][0]};

   generate
      if (EDGE_SEL) begin : g_edge_regs
         assign fall_en = {cfg_q[K_FALL][1], cfg_q[K_FALL][0]};
         assign rise_en = {cfg_q[K_RISE][1], cfg_q[K_RISE][0]};
      end else begin : g_no_edge_regs
         assign fall_en = '0;
         assign rise_en = '0;
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int N        = 32,
   parameter bit EDGE_SEL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_s,
   input  logic [N-1:0] typ,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] hold,
   input  logic [N-1:0] fall_en,
   input  logic [N-1:0] rise_en,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status,
   output logic [N-1:0] edge_hit
);
   logic [N-1:0] prev_q;
   logic [N-1:0] rise, fall;
   logic [N-1:0] level_hit;
   logic [N-1:0] stat_d;

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   generate
      if (EDGE_SEL) begin : g_sel
         assign edge_hit = (rise & rise_en) | (fall & fall_en);
      end else begin : g_pol
         assign edge_hit = (rise & pol) | (fall & ~pol);
      end
   endgenerate

   assign level_hit = ~(pin_s ^ pol);

   assign stat_d = (~typ & level_hit)
                 | (typ & ~hold & edge_hit)
                 | (typ & hold & ((status & ~clr) | edge_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= pin_s;
         status <= stat_d;
      end
   end
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
   parameter int HALF_W = 16,
   localparam int N     = 2 * HALF_W,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   logic [HALF_W-1:0] req_lo, req_hi;
   logic [IDX_W-1:0]  lo_idx, hi_idx;

   assign req_lo = req[HALF_W-1:0];
   assign req_hi = req[N-1:HALF_W];

   always_comb begin
      lo_idx = '0;
      hi_idx = '0;
      for (int i = HALF_W - 1; i >= 0; i--) begin
         if (req_lo[i]) lo_idx = IDX_W'(i);
         if (req_hi[i]) hi_idx = IDX_W'(i + HALF_W);
      end
   end

   assign valid = |req;
   assign idx   = (|req_lo) ? lo_idx : hi_idx;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_SEL    = 1'b1,
   localparam int NPIN       = 2 * HALF_W,
   localparam int IDX_W      = $clog2(NPIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic              irq_out,
   output logic [IDX_W-1:0]  pend_idx,
   output logic              pend_valid
);
   generate
      if (HALF_W < 1 || HALF_W > REG_W) begin : g_bad_half
         $error("HALF_W must lie between 1 and the register width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPIN-1:0] pin_s;
   logic [NPIN-1:0] status_w, clr_w, en_w, typ_w, pol_w, hold_w;
   logic [NPIN-1:0] fall_w, rise_w, edge_w;
   logic [NPIN-1:0] req_w;
   logic            irq_q;

   gpio_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   gpio_irq_regs #(.HALF_W(HALF_W), .EDGE_SEL(EDGE_SEL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .status(status_w), .rdata(reg_rdata),
      .clr(clr_w), .en(en_w), .typ(typ_w), .pol(pol_w), .hold(hold_w),
      .fall_en(fall_w), .rise_en(rise_w)
   );

   gpio_irq_detect #(.N(NPIN), .EDGE_SEL(EDGE_SEL)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .typ(typ_w), .pol(pol_w),
      .hold(hold_w), .fall_en(fall_w), .rise_en(rise_w), .clr(clr_w),
      .status(status_w), .edge_hit(edge_w)
   );

   assign req_w = status_w & en_w;

   gpio_irq_prio #(.HALF_W(HALF_W)) u_prio (
      .req(req_w), .idx(pend_idx), .valid(pend_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |req_w;
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
   parameter int HALF_W = 16,
   localparam int N     = 2 * HALF_W,
   localparam int IDX_W = $clog2(N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     status,
   input logic [N-1:0]     en,
   input logic [N-1:0]     typ,
   input logic [N-1:0]     pol,
   input logic [N-1:0]     hold,
   input logic [N-1:0]     clr,
   input logic [N-1:0]     pin_s,
   input logic             irq_out,
   input logic [IDX_W-1:0] pend_idx,
   input logic             pend_valid
);
   a_r2_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & en)) |=> irq_out);

   a_r2_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & en)) |=> !irq_out);

   a_r7_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid == (|(status & en)));

   a_r7_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (status[pend_idx] && en[pend_idx]));

   a_r7_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && (int'(pend_idx) >= HALF_W)) |-> !(|(status[HALF_W-1:0] & en[HALF_W-1:0])));

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            !typ[i] |=> (status[i] == ($past(pin_s[i]) == $past(pol[i]))));

         a_r4_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (typ[i] && hold[i] && status[i] && !clr[i]) |=> status[i]);
      end
   endgenerate
endmodule

bind gpio_irq_unit gpio_irq_chk #(.HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .status(status_w), .en(en_w), .typ(typ_w),
   .pol(pol_w), .hold(hold_w), .clr(clr_w), .pin_s(pin_s),
   .irq_out(irq_out), .pend_idx(pend_idx), .pend_valid(pend_valid)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [31:0] pin_in = '0;
   logic        irq_out;
   logic [4:0]  pend_idx;
   logic        pend_valid;

   int n_checks = 0;
   int n_fails  = 0;

   // bench model state
   logic [31:0] m_s1, m_s2, m_prev, m_stat;
   logic [31:0] m_en, m_typ, m_pol, m_hold, m_fall, m_rise;
   logic        m_irq;

   always #2 clk = ~clk;

   gpio_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .irq_out(irq_out), .pend_idx(pend_idx), .pend_valid(pend_valid)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] model_read(input logic [5:0] a);
      int k = int'(a[5:2]);
      int h = int'(a[1]);
      logic [31:0] v;
      case (k)
         0: v = m_stat;
         1: v = m_en;
         2: v = m_typ;
         3: v = m_pol;
         4: v = m_hold;
         5: v = m_fall;
         6: v = m_rise;
         default: v = '0;
      endcase
      return h ? v[31:16] : v[15:0];
   endfunction

   function automatic logic [5:0] model_pend(input logic [31:0] req);
      for (int i = 0; i < 32; i++) if (req[i]) return {1'b1, 5'(i)};
      return 6'd0;
   endfunction

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      m_en = '0; m_typ = '0; m_pol = '1; m_hold = '0;
      m_fall = '1; m_rise = '1; m_irq = 1'b0;
   endtask

   // one clock: drive at negedge, advance model, compare after posedge
   task automatic step(input logic [31:0] pins, input logic wr, input logic [5:0] a,
                       input logic [15:0] wd, input string tag);
      logic [31:0] clr, edg, lvl, nst, v;
      int k, h;
      logic [5:0] pe;
      @(negedge clk);
      pin_in = pins; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      k = int'(a[5:2]); h = int'(a[1]);
      clr = '0;
      if (wr && k == 0) clr = h ? {wd, 16'h0} : {16'h0, wd};
      edg = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
      lvl = ~(m_s2 ^ m_pol);
      nst = (~m_typ & lvl) | (m_typ & ~m_hold & edg) | (m_typ & m_hold & ((m_stat & ~clr) | edg));
      m_irq = |(m_stat & m_en);
      if (wr && k >= 1 && k <= 6) begin
         case (k)
            1: v = m_en; 2: v = m_typ; 3: v = m_pol;
            4: v = m_hold; 5: v = m_fall; default: v = m_rise;
         endcase
         if (h) v[31:16] = wd; else v[15:0] = wd;
         case (k)
            1: m_en = v; 2: m_typ = v; 3: m_pol = v;
            4: m_hold = v; 5: m_fall = v; default: m_rise = v;
         endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins; m_stat = nst;
      @(posedge clk);
      #1;
      pe = model_pend(m_stat & m_en);
      check(tag, "irq_out", 32'(irq_out), 32'(m_irq));
      check(tag, "pend_valid", 32'(pend_valid), 32'(pe[5]));
      if (pe[5]) check(tag, "pend_idx", 32'(pend_idx), 32'(pe[4:0]));
      check(tag, $sformatf("rdata@%0h", a), 32'(reg_rdata), 32'(model_read(a)));
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [15:0] d, input string tag);
      step(pin_in, 1'b1, a, d, tag);
   endtask

   task automatic idle(input int n, input logic [5:0] a, input string tag);
      for (int i = 0; i < n; i++) step(pin_in, 1'b0, a, 16'h0, tag);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      logic [31:0] p;
      logic [5:0]  a;
      process::self().srandom(32'd1234);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9: reset values of every mapped register
      for (int r = 0; r < 14; r++) idle(1, 6'(2 * r), "R9");

      // R10: unmapped space reads zero and ignores writes
      for (int r = 14; r < 32; r++) wr_reg(6'(2 * r), 16'hA5A5, "R10");
      for (int r = 0; r < 32; r++) idle(1, 6'(2 * r), "R10");

      // R3: level, active-low on pin 2 then active-high, clear has no lasting effect
      wr_reg(6'h04, 16'h0004, "R3");
      wr_reg(6'h0C, 16'hFFFB, "R3");
      idle(3, 6'h00, "R3");
      wr_reg(6'h00, 16'h0004, "R3");
      idle(2, 6'h00, "R3");
      step(32'h4, 1'b0, 6'h00, 0, "R8");
      idle(3, 6'h00, "R8");
      wr_reg(6'h0C, 16'hFFFF, "R3");
      idle(2, 6'h00, "R3");

      // R4 and R1: pin 3 sticky rising edge
      step(32'h0, 1'b0, 6'h00, 0, "R4");
      wr_reg(6'h08, 16'h0008, "R4");
      wr_reg(6'h10, 16'h0008, "R4");
      wr_reg(6'h14, 16'h0000, "R6");
      wr_reg(6'h04, 16'h0008, "R4");
      idle(3, 6'h00, "R4");
      step(32'h8, 1'b0, 6'h00, 0, "R8");
      idle(4, 6'h00, "R4");
      wr_reg(6'h00, 16'h0000, "R1");
      idle(2, 6'h00, "R1");
      step(32'h0, 1'b0, 6'h00, 0, "R6");
      idle(4, 6'h00, "R6");
      wr_reg(6'h00, 16'h0008, "R1");
      idle(2, 6'h00, "R1");
      // edge arriving in the same cycle as the clear: set wins
      step(32'h8, 1'b0, 6'h00, 0, "R4");
      step(32'h8, 1'b0, 6'h00, 0, "R4");
      wr_reg(6'h00, 16'h0008, "R4");
      idle(3, 6'h00, "R4");
      wr_reg(6'h00, 16'h0008, "R1");
      idle(2, 6'h00, "R1");

      // R5: pin 20 non-sticky, both edges; also level pins ignore polarity rule for edge
      wr_reg(6'h0A, 16'h0010, "R5");
      wr_reg(6'h06, 16'h0010, "R5");
      wr_reg(6'h0E, 16'h0000, "R6");
      step(32'h0010_0000, 1'b0, 6'h02, 0, "R5");
      idle(5, 6'h02, "R5");
      step(32'h0, 1'b0, 6'h02, 0, "R5");
      idle(5, 6'h02, "R5");

      // R7: high-half pending while low half pending, priority to low
      wr_reg(6'h0E, 16'hFFFF, "R7");
      wr_reg(6'h0A, 16'h0000, "R7");
      wr_reg(6'h06, 16'h8011, "R7");
      wr_reg(6'h04, 16'h0420, "R7");
      step(32'h8011_0420, 1'b0, 6'h00, 0, "R7");
      idle(4, 6'h02, "R7");
      step(32'h8011_0000, 1'b0, 6'h00, 0, "R7");
      idle(4, 6'h02, "R7");
      step(32'h8010_0000, 1'b0, 6'h00, 0, "R7");
      idle(4, 6'h02, "R2");
      step(32'h0, 1'b0, 6'h00, 0, "R2");
      idle(4, 6'h02, "R2");

      // random phase
      p = 32'h0;
      for (int n = 0; n < 4000; n++) begin
         for (int b = 0; b < 32; b++) if ($urandom_range(0, 15) == 0) p[b] = ~p[b];
         if ($urandom_range(0, 4) == 0) begin
            a = 6'(2 * $urandom_range(0, 15));
            step(p, 1'b1, a, 16'($urandom), "R1");
         end else begin
            a = ($urandom_range(0, 2) != 0) ? 6'(2 * $urandom_range(0, 1)) : 6'(2 * $urandom_range(0, 13));
            step(p, 1'b0, a, 16'h0, "R6");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule